// File: doc/BRIEF.md
# Threshold-Gated Block Correction and Scrub Sequencer

This block sits beside the per-block symbol decoder of a memory controller and decides what happens to each decoded 64-byte block. The decoder reports how many bytes it corrected and whether it gave up. A block is passed to the cache only when the decoder made few corrections: at most a programmable threshold, which resets to 2 and never exceeds half the eight check bytes. Every other outcome is treated as suspect. The block is dropped, and the sequencer starts a fallback read of the long per-chip codeword that covers it. That read is 36 block fetches, followed by one long-codeword decode result.

At boot the same sequencer walks every long codeword of every chip and hands each one to the long-codeword decoder. It walks chip by chip inside each codeword row, with the parity chip last. If the decoder reports a data chip's codeword as uncorrectable, the sequencer asks for an erasure rebuild of that chip from the parity chip. If the parity chip's codeword fails, it asks for the parity contents to be recomputed from the data chips. Two saturating counters report fallbacks and failed chips. While a fallback or a scrub is running, new block results are stalled.

Top module: `ecc_fallback_seq`

## Requirements
- R1: After reset the sequencer is idle: `rd_ready` is 1, `busy` is 0, both counters read 0, and the threshold is 2.
- R2: A block result taken while idle is accepted when `rd_uncorr` is 0 and `rd_corr_cnt` is no more than the threshold. `fwd_valid` then pulses for one cycle on the following cycle, and no fallback starts.
- R3: A block result taken while idle, with `rd_uncorr` set or `rd_corr_cnt` above the threshold, starts a fallback. From the next cycle `busy` is 1, and `fb_count` has risen by one.
- R4: A fallback raises `fetch_req` with `fetch_idx` running 0 to 35, advancing on each cycle where `fetch_gnt` is high. After the fetch granted at index 35 it waits for `lw_valid`. The cycle after `lw_valid` arrives it pulses `fb_done` and returns to idle.
- R5: A write through `cfg_we` loads `cfg_thresh` into the threshold, except that values above 4 are stored as 4. The new threshold applies to results taken after the write edge.
- R6: A scrub visits every (word, chip) pair exactly once, with the chip index 0..8 running fastest and the word index 0..NUM_WORDS-1 slowest. Chip 8 is the parity chip. Each pair is held on `scrub_word`/`scrub_chip` with `scrub_req` high until `lw_valid` arrives.
- R7: During a scrub, an uncorrectable result on a data chip (index 0..7) pulses `erase_req` on the next cycle, with `erase_chip` equal to that chip index, and adds one to `fail_count`.
- R8: During a scrub, an uncorrectable result on the parity chip pulses `parity_rebuild` on the next cycle instead of `erase_req`, and adds one to `fail_count`.
- R9: `fb_count` and `fail_count` stop at their all-ones value instead of wrapping.
- R10: While `busy` is 1, `rd_ready` is 0, and a block result offered then causes no forward, no fallback and no count change.
- R11: `scrub_start` while idle takes priority over a block result offered in the same cycle: `rd_ready` is 0 in that cycle. After the last pair is decoded, `scrub_done` pulses for one cycle and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_thresh | input | CORR_W | Requested threshold, clamped to 4 |
| rd_valid | input | 1 | Block decode result present |
| rd_ready | output | 1 | Result is taken this cycle |
| rd_corr_cnt | input | CORR_W | Bytes corrected by the block decoder |
| rd_uncorr | input | 1 | Block decoder gave up |
| fwd_valid | output | 1 | Pulse: block forwarded to cache |
| fetch_req | output | 1 | Fallback block fetch request |
| fetch_idx | output | FIDX_W | Index of the requested fetch, 0..35 |
| fetch_gnt | input | 1 | Fetch accepted |
| lw_valid | input | 1 | Long-codeword decode result present |
| lw_uncorr | input | 1 | Long codeword uncorrectable |
| fb_done | output | 1 | Pulse: fallback finished |
| scrub_start | input | 1 | Start the boot scrub |
| scrub_req | output | 1 | Scrub codeword request |
| scrub_word | output | WORD_W | Codeword row being scrubbed |
| scrub_chip | output | CHIP_W | Chip being scrubbed (8 = parity) |
| erase_req | output | 1 | Pulse: rebuild a data chip by erasure |
| erase_chip | output | CHIP_W | Chip to rebuild |
| parity_rebuild | output | 1 | Pulse: recompute parity chip |
| scrub_done | output | 1 | Pulse: scrub finished |
| busy | output | 1 | Fallback or scrub in progress |
| fb_count | output | CNT_W | Saturating fallback count |
| fail_count | output | CNT_W | Saturating failed-chip count |

## Verification
A wrong internal state shows at the ports within one cycle. A corrupted fetch index or walker position changes `fetch_idx` or `scrub_chip`/`scrub_word` on the very next compare. A mis-stored threshold shows on the next offered result that lies at its boundary, as a missing `fwd_valid` or an early `busy`. A state machine stuck out of idle keeps `rd_ready` low. The bench runs a behavioural model alongside the design and compares every output on every cycle. It drives grants and long-codeword results from a pseudo-random source, so fetch stalls, decode gaps and failures on both data and parity chips are all exercised.

// File: rtl/eccseq_pkg.sv
// Shared types for the correction/scrub sequencer.
// Assumes: nothing beyond a 2-bit state encoding.
package eccseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LWAIT = 2'd2,
        ST_SCRUB = 2'd3
    } seq_state_t;

endpackage

// File: rtl/eccseq_gate.sv
// Acceptance gate: decides whether a decoded block may be forwarded.
// Assumes: limit is already clamped to the code's random-error capacity.
module eccseq_gate #(
    parameter int CORR_W = 4
) (
    input  logic [CORR_W-1:0] corr_cnt,
    input  logic              uncorr,
    input  logic [CORR_W-1:0] limit,
    output logic              accept
);

    // Accept only a clean decode with few corrections.
    always_comb begin
        accept = !uncorr && (corr_cnt <= limit);
    end

endmodule

// File: rtl/eccseq_satcnt.sv
// Saturating event counter: holds at all-ones instead of wrapping.
// Assumes: one increment per cycle at most.
module eccseq_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] TOP = '1;

    // Count events until the ceiling is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (inc && (value != TOP)) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/eccseq_walker.sv
// Scrub position walker: chip index runs fastest, word index slowest.
// Assumes: NUM_WORDS >= 2 and NUM_CHIPS >= 2; clear and step are never
// asserted together.
module eccseq_walker #(
    parameter int NUM_WORDS = 4,
    parameter int NUM_CHIPS = 9,
    parameter int WORD_W    = 2,
    parameter int CHIP_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [WORD_W-1:0] word,
    output logic [CHIP_W-1:0] chip,
    output logic              last
);

    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(NUM_WORDS - 1);
    localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(NUM_CHIPS - 1);

    // Final pair of the walk.
    always_comb begin
        last = (word == LAST_WORD) && (chip == LAST_CHIP);
    end

    // Advance chip first, then word; wrap both at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= '0;
            chip <= '0;
        end else if (step) begin
            if (chip == LAST_CHIP) begin
                chip <= '0;
                word <= (word == LAST_WORD) ? '0 : word + 1'b1;
            end else begin
                chip <= chip + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecc_fallback_seq.sv
// Threshold-gated correction sequencer with boot scrub.
// Forwards lightly corrected blocks; sends every other outcome to a
// 36-fetch long-codeword fallback. On scrub_start it walks all long
// codewords, requesting erasure rebuild for failed data chips and parity
// recomputation for a failed parity chip.
// Assumes: the decoders answer through lw_valid/lw_uncorr, one result per
// request; the parity chip has the highest chip index.
module ecc_fallback_seq
    import eccseq_pkg::*;
#(
    parameter  int DATA_CHIPS     = 8,
    parameter  int CHECK_BYTES    = 8,
    parameter  int FETCH_BLOCKS   = 36,
    parameter  int NUM_WORDS      = 4,
    parameter  int CNT_W          = 8,
    parameter  int DEFAULT_THRESH = 2,
    localparam int CORR_W         = $clog2(CHECK_BYTES + 1),
    localparam int FIDX_W         = $clog2(FETCH_BLOCKS),
    localparam int WORD_W         = $clog2(NUM_WORDS),
    localparam int NUM_CHIPS      = DATA_CHIPS + 1,
    localparam int CHIP_W         = $clog2(NUM_CHIPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CORR_W-1:0] cfg_thresh,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [CORR_W-1:0] rd_corr_cnt,
    input  logic              rd_uncorr,
    output logic              fwd_valid,
    output logic              fetch_req,
    output logic [FIDX_W-1:0] fetch_idx,
    input  logic              fetch_gnt,
    input  logic              lw_valid,
    input  logic              lw_uncorr,
    output logic              fb_done,
    input  logic              scrub_start,
    output logic              scrub_req,
    output logic [WORD_W-1:0] scrub_word,
    output logic [CHIP_W-1:0] scrub_chip,
    output logic              erase_req,
    output logic [CHIP_W-1:0] erase_chip,
    output logic              parity_rebuild,
    output logic              scrub_done,
    output logic              busy,
    output logic [CNT_W-1:0]  fb_count,
    output logic [CNT_W-1:0]  fail_count
);

    localparam int                MAX_CORR   = CHECK_BYTES / 2;
    localparam logic [CORR_W-1:0] THR_CAP    = CORR_W'(MAX_CORR);
    localparam logic [CORR_W-1:0] THR_RESET  = CORR_W'(DEFAULT_THRESH);
    localparam logic [FIDX_W-1:0] FIDX_LAST  = FIDX_W'(FETCH_BLOCKS - 1);
    localparam logic [CHIP_W-1:0] PARITY_IDX = CHIP_W'(DATA_CHIPS);

    seq_state_t        state_q;
    logic [CORR_W-1:0] thr_q;
    logic [CORR_W-1:0] thr_d;
    logic [FIDX_W-1:0] fidx_q;
    logic              accept;
    logic              idle;
    logic              take_rd;
    logic              divert;
    logic              scrub_go;
    logic              scrub_step;
    logic              fail_hit;
    logic              walk_last;
    logic              fwd_q;
    logic              fbdone_q;
    logic              erase_q;
    logic [CHIP_W-1:0] echip_q;
    logic              prb_q;
    logic              sdone_q;

    eccseq_gate #(.CORR_W(CORR_W)) u_gate (
        .corr_cnt (rd_corr_cnt),
        .uncorr   (rd_uncorr),
        .limit    (thr_q),
        .accept   (accept)
    );

    eccseq_walker #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_CHIPS (NUM_CHIPS),
        .WORD_W    (WORD_W),
        .CHIP_W    (CHIP_W)
    ) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (scrub_go),
        .step  (scrub_step),
        .word  (scrub_word),
        .chip  (scrub_chip),
        .last  (walk_last)
    );

    eccseq_satcnt #(.W(CNT_W)) u_fbcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (divert),
        .value (fb_count)
    );

    eccseq_satcnt #(.W(CNT_W)) u_failcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fail_hit),
        .value (fail_count)
    );

    // Handshake and event decode.
    always_comb begin
        idle       = (state_q == ST_IDLE);
        rd_ready   = idle && !scrub_start;
        take_rd    = rd_valid && rd_ready;
        divert     = take_rd && !accept;
        scrub_go   = idle && scrub_start;
        scrub_step = (state_q == ST_SCRUB) && lw_valid;
        fail_hit   = scrub_step && lw_uncorr;
        thr_d      = (cfg_thresh > THR_CAP) ? THR_CAP : cfg_thresh;
    end

    // Threshold field, clamped on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= THR_RESET;
        end else if (cfg_we) begin
            thr_q <= thr_d;
        end
    end

    // Main sequencing state and fallback fetch index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fidx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (scrub_go) begin
                        state_q <= ST_SCRUB;
                    end else if (divert) begin
                        state_q <= ST_FETCH;
                        fidx_q  <= '0;
                    end
                end
                ST_FETCH: begin
                    if (fetch_gnt) begin
                        if (fidx_q == FIDX_LAST) begin
                            state_q <= ST_LWAIT;
                        end else begin
                            fidx_q <= fidx_q + 1'b1;
                        end
                    end
                end
                ST_LWAIT: begin
                    if (lw_valid) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_SCRUB: begin
                    if (scrub_step && walk_last) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // One-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q    <= 1'b0;
            fbdone_q <= 1'b0;
            erase_q  <= 1'b0;
            echip_q  <= '0;
            prb_q    <= 1'b0;
            sdone_q  <= 1'b0;
        end else begin
            fwd_q    <= take_rd && accept;
            fbdone_q <= (state_q == ST_LWAIT) && lw_valid;
            erase_q  <= fail_hit && (scrub_chip != PARITY_IDX);
            prb_q    <= fail_hit && (scrub_chip == PARITY_IDX);
            sdone_q  <= scrub_step && walk_last;
            if (fail_hit && (scrub_chip != PARITY_IDX)) begin
                echip_q <= scrub_chip;
            end
        end
    end

    // Output mapping.
    always_comb begin
        busy           = !idle;
        fetch_req      = (state_q == ST_FETCH);
        fetch_idx      = fidx_q;
        scrub_req      = (state_q == ST_SCRUB);
        fwd_valid      = fwd_q;
        fb_done        = fbdone_q;
        erase_req      = erase_q;
        erase_chip     = echip_q;
        parity_rebuild = prb_q;
        scrub_done     = sdone_q;
    end

endmodule

// File: rtl/eccseq_checker.sv
// Property checker for ecc_fallback_seq, attached by bind.
// Assumes: thr is the stored threshold of the bound instance.
module eccseq_checker #(
    parameter int CORR_W   = 4,
    parameter int CNT_W    = 8,
    parameter int MAX_CORR = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [CORR_W-1:0] rd_corr_cnt,
    input logic              rd_uncorr,
    input logic [CORR_W-1:0] thr,
    input logic              busy,
    input logic              fetch_req,
    input logic              fwd_valid,
    input logic              fb_done,
    input logic              erase_req,
    input logic              parity_rebuild,
    input logic [CNT_W-1:0]  fb_count,
    input logic [CNT_W-1:0]  fail_count
);

    AST_ACCEPT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !rd_uncorr && rd_corr_cnt <= thr) |=> (fwd_valid && !busy)); // R2
    AST_DIVERT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && (rd_uncorr || rd_corr_cnt > thr)) |=> (busy && fetch_req)); // R3
    AST_FETCH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (busy && !rd_ready)); // R4
    AST_THR_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        thr <= CORR_W'(MAX_CORR)); // R5
    AST_FB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fb_count) |-> fb_count == CNT_W'($past(fb_count) + 1'b1)); // R9
    AST_FAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fail_count) |-> fail_count == CNT_W'($past(fail_count) + 1'b1)); // R9
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_ready); // R10
    AST_REPAIR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, fb_done, erase_req, parity_rebuild})); // R8

endmodule

bind ecc_fallback_seq eccseq_checker #(
    .CORR_W   (CORR_W),
    .CNT_W    (CNT_W),
    .MAX_CORR (MAX_CORR)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_valid       (rd_valid),
    .rd_ready       (rd_ready),
    .rd_corr_cnt    (rd_corr_cnt),
    .rd_uncorr      (rd_uncorr),
    .thr            (thr_q),
    .busy           (busy),
    .fetch_req      (fetch_req),
    .fwd_valid      (fwd_valid),
    .fb_done        (fb_done),
    .erase_req      (erase_req),
    .parity_rebuild (parity_rebuild),
    .fb_count       (fb_count),
    .fail_count     (fail_count)
);

// File: tb/tb_ecc_fallback_seq.sv
// Bench: behavioural reference model compared on every clock.
module tb_ecc_fallback_seq;

    localparam int NW     = 2;
    localparam int NCHIP  = 9;
    localparam int NFETCH = 36;
    localparam int CMAX   = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_thresh = '0;
    logic       rd_valid = 1'b0;
    logic       rd_ready;
    logic [3:0] rd_corr_cnt = '0;
    logic       rd_uncorr = 1'b0;
    logic       fwd_valid;
    logic       fetch_req;
    logic [5:0] fetch_idx;
    logic       fetch_gnt = 1'b0;
    logic       lw_valid = 1'b0;
    logic       lw_uncorr = 1'b0;
    logic       fb_done;
    logic       scrub_start = 1'b0;
    logic       scrub_req;
    logic       scrub_word;
    logic [3:0] scrub_chip;
    logic       erase_req;
    logic [3:0] erase_chip;
    logic       parity_rebuild;
    logic       scrub_done;
    logic       busy;
    logic [2:0] fb_count;
    logic [2:0] fail_count;

    ecc_fallback_seq #(.NUM_WORDS(NW), .CNT_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thresh(cfg_thresh),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_corr_cnt(rd_corr_cnt),
        .rd_uncorr(rd_uncorr), .fwd_valid(fwd_valid), .fetch_req(fetch_req),
        .fetch_idx(fetch_idx), .fetch_gnt(fetch_gnt), .lw_valid(lw_valid),
        .lw_uncorr(lw_uncorr), .fb_done(fb_done), .scrub_start(scrub_start),
        .scrub_req(scrub_req), .scrub_word(scrub_word), .scrub_chip(scrub_chip),
        .erase_req(erase_req), .erase_chip(erase_chip),
        .parity_rebuild(parity_rebuild), .scrub_done(scrub_done), .busy(busy),
        .fb_count(fb_count), .fail_count(fail_count)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lw_mode = 1;
    logic [15:0] lfsr = 16'hACE1;

    // Reference model state
    int m_state = 0;
    int m_fidx = 0, m_word = 0, m_chip = 0, m_thr = 2, m_fb = 0, m_fail = 0;
    int m_fwd = 0, m_fbd = 0, m_er = 0, m_ech = 0, m_prb = 0, m_sd = 0;

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Pseudo-random responder for grants and long-codeword results.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        fetch_gnt = lfsr[0] | lfsr[3];
        lw_valid  = lfsr[1] | lfsr[6];
        lw_uncorr = (lw_mode == 2) ? 1'b1 : (lfsr[5] & lfsr[8]);
    end

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_fidx = 0; m_word = 0; m_chip = 0; m_thr = 2;
            m_fb = 0; m_fail = 0; m_fwd = 0; m_fbd = 0; m_er = 0; m_ech = 0;
            m_prb = 0; m_sd = 0;
        end else begin
            m_fwd = 0; m_fbd = 0; m_er = 0; m_prb = 0; m_sd = 0;
            case (m_state)
                0: if (scrub_start) begin
                       m_state = 3; m_word = 0; m_chip = 0;
                   end else if (rd_valid) begin
                       if (!rd_uncorr && int'(rd_corr_cnt) <= m_thr) m_fwd = 1;
                       else begin
                           m_state = 1; m_fidx = 0;
                           if (m_fb < CMAX) m_fb++;
                       end
                   end
                1: if (fetch_gnt) begin
                       if (m_fidx == NFETCH - 1) m_state = 2; else m_fidx++;
                   end
                2: if (lw_valid) begin m_state = 0; m_fbd = 1; end
                default: if (lw_valid) begin
                       if (lw_uncorr) begin
                           if (m_fail < CMAX) m_fail++;
                           if (m_chip < NCHIP - 1) begin m_er = 1; m_ech = m_chip; end
                           else m_prb = 1;
                       end
                       if (m_chip == NCHIP - 1) begin
                           m_chip = 0;
                           if (m_word == NW - 1) begin m_state = 0; m_sd = 1; m_word = 0; end
                           else m_word++;
                       end else m_chip++;
                   end
            endcase
            if (cfg_we) m_thr = (cfg_thresh > 4) ? 4 : int'(cfg_thresh);
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            cmp("R10 R11", "rd_ready", int'(rd_ready), int'(m_state == 0 && !scrub_start));
            cmp("R3", "busy", int'(busy), int'(m_state != 0));
            cmp("R2 R5", "fwd_valid", int'(fwd_valid), m_fwd);
            cmp("R4", "fetch_req", int'(fetch_req), int'(m_state == 1));
            if (m_state == 1) cmp("R4", "fetch_idx", int'(fetch_idx), m_fidx);
            cmp("R4", "fb_done", int'(fb_done), m_fbd);
            cmp("R6", "scrub_req", int'(scrub_req), int'(m_state == 3));
            if (m_state == 3) begin
                cmp("R6", "scrub_word", int'(scrub_word), m_word);
                cmp("R6", "scrub_chip", int'(scrub_chip), m_chip);
            end
            cmp("R7", "erase_req", int'(erase_req), m_er);
            if (m_er != 0) cmp("R7", "erase_chip", int'(erase_chip), m_ech);
            cmp("R8", "parity_rebuild", int'(parity_rebuild), m_prb);
            cmp("R11", "scrub_done", int'(scrub_done), m_sd);
            cmp("R3 R9", "fb_count", int'(fb_count), m_fb);
            cmp("R7 R9", "fail_count", int'(fail_count), m_fail);
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_state != 0) @(negedge clk);
    endtask

    task automatic send_read(input int c, input bit u);
        wait_idle();
        @(posedge clk); #1;
        rd_valid = 1'b1; rd_corr_cnt = 4'(c); rd_uncorr = u;
        @(posedge clk); #1;
        rd_valid = 1'b0; rd_uncorr = 1'b0;
    endtask

    task automatic set_thr(input int t);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_thresh = 4'(t);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic start_scrub();
        wait_idle();
        @(posedge clk); #1;
        scrub_start = 1'b1;
        @(posedge clk); #1;
        scrub_start = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #750000;
        errors++;
        $display("FAIL R4 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus
    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cmp("R1", "reset rd_ready", int'(rd_ready), 1);
        cmp("R1", "reset busy", int'(busy), 0);
        cmp("R1", "reset fb_count", int'(fb_count), 0);
        cmp("R1", "reset fail_count", int'(fail_count), 0);
        // R1/R2: default threshold 2 accepts 0..2 corrections
        send_read(0, 0);
        send_read(1, 0);
        send_read(2, 0);
        // R3/R4: three corrections divert to a fallback
        send_read(3, 0);
        // R10: offer a result while busy
        @(posedge clk); #1 rd_valid = 1'b1; rd_corr_cnt = 4'd0;
        @(posedge clk); #1 rd_valid = 1'b0;
        // R3: uncorrectable with zero corrections diverts
        send_read(0, 1);
        // R5: write above the cap stores 4
        wait_idle();
        set_thr(7);
        send_read(4, 0);
        send_read(5, 0);
        set_thr(0);
        send_read(0, 0);
        send_read(1, 0);
        // R6/R7/R8: scrub with random failures
        lw_mode = 1;
        start_scrub();
        // R8/R9: every codeword fails, fail_count saturates
        wait_idle();
        lw_mode = 2;
        start_scrub();
        wait_idle();
        lw_mode = 1;
        // R9: more fallbacks drive fb_count to its ceiling
        for (int i = 0; i < 5; i++) send_read(4, 0);
        wait_idle();
        // R11: scrub_start wins over a simultaneous result
        @(posedge clk); #1 scrub_start = 1'b1; rd_valid = 1'b1; rd_corr_cnt = 4'd0;
        @(posedge clk); #1 scrub_start = 1'b0; rd_valid = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        cmp("R9", "fb_count saturated", int'(fb_count), CMAX);
        cmp("R9", "fail_count saturated", int'(fail_count), CMAX);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule